// File: doc/BRIEF.md
# Dual Integer Unit Issue Scoreboard

This block decides, cycle by cycle, whether an integer operation can be sent to one of two execution units that run multi-cycle work without pipelining. Each request carries a 3-bit operation class and a tag. In the same cycle the block grants the request or withholds it, and names the chosen unit. It holds that unit busy for the class's occupancy. Later it raises a one-cycle result pulse that carries the tag, in the cycle the class's latency runs out.

Each unit has a down-counter for its occupancy. A small pool of per-operation latency trackers produces the result pulses. The completion path is a single output port. For that reason a request is also withheld if its result would land in the same cycle as a result already scheduled, or if every tracker is in use. A withheld request must be held stable by the requester until it is granted. Register dependencies and the arithmetic itself belong to other blocks.

Top module: `dual_iu_scoreboard`

## Requirements
- R1: After reset both units are free, no tracker is in use, `done_valid` is low, and `grant` is low while `req_valid` is low.
- R2: Class codes, written as code (occupancy cycles, latency cycles, allowed units):
  - 0 ALU (1, 2, either)
  - 1 compare-with-record (1, 3, either)
  - 2 short multiply (3, 4, either)
  - 3 32-bit multiply (4, 5, either)
  - 4 64-bit multiply (6, 7, either)
  - 5 32-bit divide (35, 36, unit 1 only)
  - 6 64-bit divide (67, 68, unit 1 only)
  - 7 special-register move (1, 3, unit 0 only)

  When both allowed units are free, unit 0 (`grant_unit`=0) is chosen.
- R3: An operation granted in cycle t makes `done_valid` high in cycle t+latency, with `done_tag` equal to its request tag.
- R4: A unit granted in cycle t is not granted again before cycle t+occupancy, and it may be granted again in that cycle.
- R5: Classes 5 and 6 are only ever granted on unit 1; while unit 1 is busy they are withheld even if unit 0 is free.
- R6: Class 7 is only ever granted on unit 0; while unit 0 is busy it is withheld even if unit 1 is free.
- R7: When no allowed unit is free the grant is withheld; a request held stable is granted in the first cycle its unit becomes free and no other rule blocks it.
- R8: A request is withheld when its result cycle equals that of an operation already in flight, so at most one result is reported per cycle.
- R9: A request is withheld while all NSLOT trackers hold operations whose result cycle is still ahead; a tracker is released in the cycle its result is reported.
- R10: `done_valid` is a one-cycle pulse per granted operation.
- R11: With `req_valid` low no grant is given and no state changes, whatever `req_class` and `req_tag` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 3 | Operation class code (R2) |
| req_tag | input | TAG_W | Tag returned with the result |
| grant | output | 1 | Request issued this cycle |
| grant_unit | output | 1 | Selected unit, 0 or 1 (meaningful with grant) |
| done_valid | output | 1 | Result-ready pulse |
| done_tag | output | TAG_W | Tag of the operation whose result is ready |

## Verification
Each class is first issued alone on an idle block. This isolates its latency and shows the preference for unit 0. The bench then tries three kinds of back-to-back sequences:
- pairs of multiplies, which tell occupancy apart from latency and show the spill to unit 1;
- divides and register moves against a busy restricted unit, which separate the unit restriction from general availability;
- a compare followed at once by an ALU operation, whose results would land in the same cycle.

A long divide with short operations under it fills the tracker pool, so a stall from a full pool is seen apart from a unit or result-port conflict. Idle cycles with changing class and tag show that requests without the valid bit have no effect.

// File: rtl/isu_pkg.sv
package isu_pkg;

  localparam int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    OP_ALU   = 3'd0,
    OP_CMP   = 3'd1,
    OP_MULS  = 3'd2,
    OP_MUL32 = 3'd3,
    OP_MUL64 = 3'd4,
    OP_DIV32 = 3'd5,
    OP_DIV64 = 3'd6,
    OP_SPR   = 3'd7
  } op_class_e;

  // cycles a unit stays held by one operation of the class
  function automatic int occ_of(op_class_e c);
    case (c)
      OP_MULS:  return 3;
      OP_MUL32: return 4;
      OP_MUL64: return 6;
      OP_DIV32: return 35;
      OP_DIV64: return 67;
      default:  return 1;
    endcase
  endfunction

  // cycles from grant to result-ready
  function automatic int lat_of(op_class_e c);
    case (c)
      OP_ALU:   return 2;
      OP_CMP:   return 3;
      OP_MULS:  return 4;
      OP_MUL32: return 5;
      OP_MUL64: return 7;
      OP_DIV32: return 36;
      OP_DIV64: return 68;
      default:  return 3;
    endcase
  endfunction

  // bit u set: unit u may run the class
  function automatic logic [1:0] units_of(op_class_e c);
    case (c)
      OP_DIV32, OP_DIV64: return 2'b10;
      OP_SPR:             return 2'b01;
      default:            return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/isu_class_decode.sv
module isu_class_decode
  import isu_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CLASS_W-1:0] cls,
  output logic [CNT_W-1:0]   occ_m1,
  output logic [CNT_W-1:0]   lat,
  output logic [1:0]         allow
);

  op_class_e c;

  always_comb begin
    c      = op_class_e'(cls);
    occ_m1 = CNT_W'(occ_of(c) - 1);
    lat    = CNT_W'(lat_of(c));
    allow  = units_of(c);
  end

endmodule

// File: rtl/isu_busy_ctr.sv
module isu_busy_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             free
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign free = (remain == '0);

  // R4: a unit is only loaded while it is free
  p_load_when_free_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> free);

  // R4: a multi-cycle load keeps the unit held in the next cycle
  p_hold_after_load_r4: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !free);

endmodule

// File: rtl/isu_lat_pool.sv
module isu_lat_pool #(
  parameter int NSLOT = 3,
  parameter int CNT_W = 7,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic [CNT_W-1:0] alloc_lat,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic             can_alloc,
  output logic             clash,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag
);

  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0] slot_v;
  logic [CNT_W-1:0] slot_cnt [NSLOT];
  logic [TAG_W-1:0] slot_tag [NSLOT];
  logic [NSLOT-1:0] fire;
  logic [TAG_W-1:0] fire_tag;
  logic [IDX_W-1:0] free_idx;
  logic             found;

  always_comb begin
    free_idx = '0;
    found    = 1'b0;
    clash    = 1'b0;
    fire     = '0;
    fire_tag = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!slot_v[i] && !found) begin
        free_idx = IDX_W'(i);
        found    = 1'b1;
      end
      // a slot holding count c reports its result c cycles from now
      if (slot_v[i] && slot_cnt[i] == alloc_lat) clash = 1'b1;
      fire[i] = slot_v[i] && (slot_cnt[i] == CNT_W'(1));
      if (fire[i]) fire_tag = fire_tag | slot_tag[i];
    end
  end

  assign can_alloc = found;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_v[g]   <= 1'b0;
        slot_cnt[g] <= '0;
        slot_tag[g] <= '0;
      end else if (alloc && free_idx == IDX_W'(g)) begin
        slot_v[g]   <= 1'b1;
        slot_cnt[g] <= alloc_lat - CNT_W'(1);
        slot_tag[g] <= alloc_tag;
      end else if (slot_v[g]) begin
        slot_cnt[g] <= slot_cnt[g] - CNT_W'(1);
        if (slot_cnt[g] == CNT_W'(1)) slot_v[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
    end else begin
      done_valid <= |fire;
      done_tag   <= fire_tag;
    end
  end

  // R8: never two results expiring in the same cycle
  p_single_fire_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire));

  // R8: no allocation onto an occupied result cycle
  p_alloc_no_clash_r8: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !clash);

  // R9: allocation only with a free tracker
  p_alloc_room_r9: assert property (@(posedge clk) disable iff (rst)
    alloc |-> can_alloc);

endmodule

// File: rtl/dual_iu_scoreboard.sv
module dual_iu_scoreboard
  import isu_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int NSLOT = 3,
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [CLASS_W-1:0] req_class,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               grant,
  output logic               grant_unit,
  output logic               done_valid,
  output logic [TAG_W-1:0]   done_tag
);

  localparam int NUNIT = 2;

  logic [CNT_W-1:0] occ_m1;
  logic [CNT_W-1:0] lat;
  logic [1:0]       allow;
  logic [NUNIT-1:0] unit_free;
  logic [NUNIT-1:0] unit_load;
  logic [NUNIT-1:0] unit_ok;
  logic             can_alloc;
  logic             clash;

  isu_class_decode #(.CNT_W(CNT_W)) u_dec (
    .cls    (req_class),
    .occ_m1 (occ_m1),
    .lat    (lat),
    .allow  (allow)
  );

  assign unit_ok    = allow & unit_free;
  assign grant      = req_valid && (unit_ok != '0) && !clash && can_alloc;
  assign grant_unit = !unit_ok[0];

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    assign unit_load[u] = grant && (grant_unit == u[0]);

    isu_busy_ctr #(.CNT_W(CNT_W)) u_busy (
      .clk      (clk),
      .rst      (rst),
      .load     (unit_load[u]),
      .load_val (occ_m1),
      .free     (unit_free[u])
    );
  end

  isu_lat_pool #(
    .NSLOT (NSLOT),
    .CNT_W (CNT_W),
    .TAG_W (TAG_W)
  ) u_pool (
    .clk        (clk),
    .rst        (rst),
    .alloc      (grant),
    .alloc_lat  (lat),
    .alloc_tag  (req_tag),
    .can_alloc  (can_alloc),
    .clash      (clash),
    .done_valid (done_valid),
    .done_tag   (done_tag)
  );

  // R5: divides only on unit 1
  p_div_on_second_r5: assert property (@(posedge clk) disable iff (rst)
    (grant && (req_class == OP_DIV32 || req_class == OP_DIV64)) |-> grant_unit);

  // R6: register moves only on unit 0
  p_spr_on_first_r6: assert property (@(posedge clk) disable iff (rst)
    (grant && req_class == OP_SPR) |-> !grant_unit);

  // R11: no grant without a request
  p_grant_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !grant);

  // R4: at most one unit loaded per cycle
  p_one_load_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_load));

endmodule

// File: tb/tb_dual_iu_scoreboard.sv
`timescale 1ns/1ps
module tb_dual_iu_scoreboard;

  localparam int TAG_W = 4;
  localparam int NSLOT = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [2:0]       req_class = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             grant;
  logic             grant_unit;
  logic             done_valid;
  logic [TAG_W-1:0] done_tag;

  dual_iu_scoreboard #(.TAG_W(TAG_W), .NSLOT(NSLOT), .CNT_W(7)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_tag(req_tag), .grant(grant), .grant_unit(grant_unit),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  always #2.5 clk = ~clk;

  int nchk  = 0;
  int nfail = 0;
  int now   = 0;
  int busy_until [2];
  bit pv [8];
  int pd [8];
  int pt [8];
  bit last_grant;

  function automatic int occ_f(int c);
    case (c)
      2: return 3; 3: return 4; 4: return 6; 5: return 35; 6: return 67;
      default: return 1;
    endcase
  endfunction

  function automatic int lat_f(int c);
    case (c)
      0: return 2; 1: return 3; 2: return 4; 3: return 5; 4: return 7;
      5: return 36; 6: return 68; default: return 3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string lbl, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", lbl, what, act, exp, now);
    end
  endtask

  // one cycle: drive, compare with the reference model, advance the model
  task automatic step(input bit v, input int cls, input int tag, input string lbl);
    int l, o, npend, eu, et;
    bit a0, a1, ok0, ok1, cl, eg, ed;
    @(negedge clk);
    req_valid = v; req_class = 3'(cls); req_tag = TAG_W'(tag);
    #1;
    l = lat_f(cls); o = occ_f(cls);
    a0 = (cls != 5 && cls != 6);
    a1 = (cls != 7);
    ok0 = a0 && (now >= busy_until[0]);
    ok1 = a1 && (now >= busy_until[1]);
    cl = 0; npend = 0; ed = 0; et = 0;
    for (int i = 0; i < 8; i++) begin
      if (pv[i]) begin
        if (pd[i] == now + l) cl = 1;
        if (pd[i] > now) npend++;
        if (pd[i] == now) begin ed = 1; et = pt[i]; end
      end
    end
    eg = v && (ok0 || ok1) && !cl && (npend < NSLOT);
    eu = ok0 ? 0 : 1;
    chk(grant === eg, lbl, "grant", int'(grant), int'(eg));
    if (eg) chk(grant_unit === eu[0], lbl, "grant_unit", int'(grant_unit), eu);
    chk(done_valid === ed, "R3/R10", "done_valid", int'(done_valid), int'(ed));
    if (ed) chk(done_tag === TAG_W'(et), "R3", "done_tag", int'(done_tag), et);
    for (int i = 0; i < 8; i++) if (pv[i] && pd[i] <= now) pv[i] = 0;
    if (eg) begin
      for (int i = 0; i < 8; i++) begin
        if (!pv[i]) begin pv[i] = 1; pd[i] = now + l; pt[i] = tag; break; end
      end
      busy_until[eu] = now + o;
    end
    last_grant = eg;
    now++;
  endtask

  // hold a request stable until it is granted
  task automatic issue(input int cls, input int tag, input string lbl);
    int tries = 0;
    do begin
      step(1, cls, tag, lbl);
      tries++;
    end while (!last_grant && tries < 200);
    chk(last_grant, lbl, "eventually granted", int'(last_grant), 1);
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) step(0, k % 8, k, "R11");
  endtask

  task automatic t_reset;
    step(0, 0, 0, "R1");
    step(0, 5, 3, "R1");
  endtask

  task automatic t_prefer;
    issue(0, 1, "R2");        // idle: unit 0
    drain(3);
    issue(3, 2, "R2");        // 32-bit multiply on unit 0
    issue(0, 3, "R2");        // spills to unit 1
    drain(8);
  endtask

  task automatic t_latency;
    int cl [6] = '{0, 1, 2, 3, 4, 7};
    for (int k = 0; k < 6; k++) begin
      issue(cl[k], k + 4, "R3");
      drain(9);
    end
  endtask

  task automatic t_occupancy;
    issue(3, 1, "R4");
    issue(3, 2, "R4");
    issue(3, 3, "R7");        // waits for unit 0 to free at +4
    drain(10);
    issue(4, 5, "R4");
    issue(4, 6, "R4");
    issue(2, 7, "R7");
    drain(12);
  endtask

  task automatic t_div;
    issue(5, 8, "R5");        // unit 1 only
    issue(0, 9, "R5");        // unit 0 still usable
    issue(6, 10, "R5");       // held until unit 1 frees
    drain(72);
  endtask

  task automatic t_spr;
    issue(4, 11, "R6");       // unit 0 busy 6 cycles
    issue(7, 12, "R6");       // held although unit 1 is free
    drain(6);
  endtask

  task automatic t_bus;
    issue(1, 13, "R8");       // result at +3
    issue(0, 14, "R8");       // would also land at +3: withheld once
    drain(6);
  endtask

  task automatic t_full;
    issue(6, 1, "R9");        // long divide on unit 1
    issue(1, 2, "R9");
    issue(7, 3, "R9");
    issue(1, 4, "R9");        // all trackers taken for one cycle
    drain(72);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 8; k++) step(0, 7 - k, 15 - k, "R11");
    issue(0, 15, "R11");
    drain(4);
  endtask

  initial begin
    busy_until[0] = 0; busy_until[1] = 0;
    for (int i = 0; i < 8; i++) pv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_prefer();
    t_latency();
    t_occupancy();
    t_div();
    t_spr();
    t_bus();
    t_full();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule